// File: doc/BRIEF.md
# Deserializer Bit-Slip Word Realigner

This block follows a serial-to-parallel converter. On every low-speed clock cycle it takes in one J-bit parallel word, where J is 8 or 10. It keeps the last two words, an older one and a newer one. Its output is a J-bit window cut from the pair. The offset of that window is held in a slip counter that counts modulo J.

Logic downstream moves the word boundary by raising an align request. The request is synchronized with two flops and then passed to a rising-edge detector. Each rising edge moves the window one bit, however long the request then stays high. When the offset would reach J, the window is the newer word in full. In that cycle the counter returns to zero and the output is marked not valid, so the word that would otherwise appear twice is dropped. Correctly framed words continue on the next cycle.

Bits are LSB-first. The data word is bit 0 up to bit J-1, and with offset k the window is bits [k +: J] of {newer, older}.

Top module: `bitslip_realigner`

## Requirements
- R1: With offset 0 and no slip, data_o after rising edge e equals the word that data_i held at edge e-2.
- R2: With offset k in 1..J-1, data_o after edge e equals bits [k +: J] of {word at edge e-1, word at edge e-2}. Bit 0 is the first-received bit.
- R3: Suppose align_req_i is sampled low at edge a-1 and high at edge a. The output registered at edge a+2 is then the first to use the new offset.
- R4: Exactly one slip happens per rising edge of align_req_i, even when the request is held high for many cycles.
- R5: The counter advances by one per slip and stays in 0..J-1. The slip taken at J-1 produces output equal to the whole newer word (the word at edge e-1), and the counter returns to 0.
- R6: valid_o is low for the output registered at the wrapping slip, and high again on the next edge.
- R7: After reset is released, valid_o stays low for the outputs of the first two edges and goes high from the third.
- R8: While rst_ni is low (asynchronous, active low), data_o is 0 and valid_o is 0. Once reset is released, the offset is 0 and no slip is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed (word) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | J | Parallel word from the deserializer, bit 0 first received |
| align_req_i | input | 1 | Slip request; every rising edge moves the boundary one bit; hold high for two or more cycles |
| data_o | output | J | Realigned word |
| valid_o | output | 1 | data_o carries a framed word |

## Verification
The assertions are checked on every cycle. They cover the following:
- the counter stays in range and steps by one per slip;
- the counter returns to zero on a wrap;
- an edge pulse never lasts more than one cycle;
- a wrap always makes the next output not valid;
- offsets 0 and J pick out the older and the newer word whole.

Only the bench scenarios can show the end-to-end framing. It sweeps every offset through repeated wraps and compares each output with an arithmetic model of the bit stream. It also confirms the two-edge latency from request to output, the behaviour of long-held requests, and the valid pattern after a reset in the middle of a run.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  // width of a selector that can hold 0..j
  function automatic int sel_width(input int j);
    return $clog2(j + 1);
  endfunction
endpackage

// File: rtl/bsr_req_sync.sv
module bsr_req_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic slip_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], req_i};
  end

  // sh_q[1:0] synchronizer, sh_q[2] edge history
  assign slip_o = sh_q[1] & ~sh_q[2];

  // R4
  single_slip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o);
endmodule

// File: rtl/bsr_slip_ctrl.sv
module bsr_slip_ctrl #(
  parameter int J  = 8,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slip_i,
  output logic [SW-1:0] sel_o,
  output logic          wrap_o
);
  localparam logic [SW-1:0] LAST = SW'(J - 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign wrap_o  = slip_i & at_last;
  // offset used this cycle: J on a wrap selects the newer word whole
  assign sel_o   = cnt_q + SW'(slip_i);

  always_comb begin
    cnt_d = cnt_q;
    if (wrap_o)      cnt_d = '0;
    else if (slip_i) cnt_d = cnt_q + SW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R5
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_i && at_last) |=> (cnt_q == '0));
  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_i && !at_last) |=> (cnt_q == $past(cnt_q) + SW'(1)));
endmodule

// File: rtl/bsr_word_pipe.sv
module bsr_word_pipe #(
  parameter int J  = 8,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [J-1:0]  data_i,
  input  logic [SW-1:0] sel_i,
  output logic [J-1:0]  data_o
);
  logic [J-1:0]   newer_q, older_q, data_q;
  logic [2*J-1:0] win;
  logic [J-1:0]   cand [0:J];

  assign win = {newer_q, older_q};

  for (genvar k = 0; k <= J; k++) begin : g_cand
    assign cand[k] = win[k +: J];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      newer_q <= '0;
      older_q <= '0;
      data_q  <= '0;
    end else begin
      newer_q <= data_i;
      older_q <= newer_q;
      data_q  <= cand[sel_i];
    end
  end

  assign data_o = data_q;

  // R1
  zero_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |=> (data_o == $past(older_q)));
  // R5
  full_newer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SW'(J)) |=> (data_o == $past(newer_q)));
endmodule

// File: rtl/bitslip_realigner.sv
module bitslip_realigner #(
  parameter int J = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [J-1:0] data_i,
  input  logic         align_req_i,
  output logic [J-1:0] data_o,
  output logic         valid_o
);
  localparam int SW = bsr_pkg::sel_width(J);

  if (J != 8 && J != 10) begin : g_bad_j
    $error("bitslip_realigner: J must be 8 or 10");
  end

  logic          slip;
  logic          wrap;
  logic [SW-1:0] sel;
  logic          newer_ok_q, older_ok_q, valid_q;

  bsr_req_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (align_req_i),
    .slip_o (slip)
  );

  bsr_slip_ctrl #(.J(J), .SW(SW)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slip_i (slip),
    .sel_o  (sel),
    .wrap_o (wrap)
  );

  bsr_word_pipe #(.J(J), .SW(SW)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .sel_i  (sel),
    .data_o (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      newer_ok_q <= 1'b0;
      older_ok_q <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      newer_ok_q <= 1'b1;
      older_ok_q <= newer_ok_q;
      valid_q    <= older_ok_q & ~wrap;
    end
  end

  assign valid_o = valid_q;

  // R6
  wrap_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> !valid_o);
  // R7
  fill_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !older_ok_q |=> !valid_o);
endmodule

// File: tb/bitslip_realigner_bench.sv
module bitslip_realigner_bench;
  localparam int J = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [J-1:0] data_in = '0;
  logic         req = 1'b0;
  logic [J-1:0] data_out;
  logic         valid_out;

  int n_chk = 0, n_bad = 0, word_k = 0;
  bit done = 0;
  string tag = "R8";

  always #10 clk = ~clk;

  bitslip_realigner #(.J(J)) u_bitslip_realigner (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_in),
    .align_req_i(req), .data_o(data_out), .valid_o(valid_out)
  );

  // stream model
  int           e_cnt = 0, mc = 0;
  bit           h1 = 0, h2 = 0, h3 = 0;
  logic [J-1:0] p1 = '0, p2 = '0, exp_data = '0;
  bit           exp_valid = 0, exp_wrap = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_cnt = 0; mc = 0; h1 = 0; h2 = 0; h3 = 0;
      p1 = '0; p2 = '0; exp_data = '0; exp_valid = 0; exp_wrap = 0;
    end else begin
      bit slip;
      int s;
      logic [2*J-1:0] cat;
      e_cnt++;
      slip = h2 && !h3;                          // R3 latency
      s = mc + (slip ? 1 : 0);
      exp_wrap = slip && (mc == J - 1);
      cat = {p1, p2};
      exp_data = J'(cat >> s);
      exp_valid = (e_cnt >= 3) && !exp_wrap;
      if (exp_wrap) mc = 0; else if (slip) mc++;
      h3 = h2; h2 = h1; h1 = req;
      p2 = p1; p1 = data_in;
    end
  end

  task automatic check();
    n_chk++;
    if (!rst_n) begin
      if (data_out !== '0 || valid_out !== 1'b0) begin
        n_bad++;
        $display("FAIL R8 reset: data=%h valid=%b exp data=0 valid=0", data_out, valid_out);
      end
    end else begin
      if (valid_out !== exp_valid) begin
        n_bad++;
        $display("FAIL %s/R6/R7 valid: act=%b exp=%b", tag, valid_out, exp_valid);
      end
      if ((exp_valid || exp_wrap) && data_out !== exp_data) begin
        n_bad++;
        $display("FAIL %s data%s: act=%h exp=%h", tag, exp_wrap ? " R5 wrap" : "",
                 data_out, exp_data);
      end
    end
  endtask

  task automatic step(input bit r);
    @(negedge clk);
    check();
    req = r;
    data_in = J'((word_k * 37 + 11) ^ (word_k >> 3));
    word_k++;
  endtask

  task automatic pulse(input int hi, input int lo);
    for (int i = 0; i < hi; i++) step(1'b1);
    for (int i = 0; i < lo; i++) step(1'b0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step(1'b0);       // R8
    rst_n = 1'b1;
    tag = "R7";
    for (int i = 0; i < 4; i++) step(1'b0);
    tag = "R1";
    for (int i = 0; i < 16; i++) step(1'b0);
    tag = "R2";                                    // R3, R5 covered by the sweep
    for (int n = 0; n < 3 * J + 3; n++) pulse(2, 4);
    tag = "R3";
    for (int n = 0; n < J; n++) pulse(2, 2);
    tag = "R4";
    for (int n = 0; n < J + 2; n++) pulse(15, 5);
    tag = "R8";
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0);
    rst_n = 1'b1;
    tag = "R7";
    for (int i = 0; i < 6; i++) step(1'b0);
    tag = "R5";
    for (int n = 0; n < 2 * J + 1; n++) pulse(3, 3);
    for (int i = 0; i < 8; i++) step(1'b0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule